// File: doc/BRIEF.md
# Periodic CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous, address-multiplexed DRAM alive by issuing refresh cycles in which the column strobe falls before the row strobe. In that kind of refresh the device uses its own internal row counter, so no address is driven. The block sits next to the host access controller and shares the DRAM strobes with it through a request/grant handshake. It raises a request and waits for the grant. It then drives every row-strobe bank line and every column-strobe lane together, with the write-enable held high, for as many refresh cycles as are owed. When the batch is done it drops the request.

After reset the block first waits out a power-up pause. It then runs a burst of wake-up refreshes and only after that reports the memory as ready for normal access. In normal operation an interval timer adds one owed refresh per period. Up to a fixed number of owed refreshes may pile up while the host keeps the bus. If the timer fires once more beyond that budget, the refresh deadline counts as missed. The ready flag then drops, and the wake-up burst is owed again.

All timing minima are given in nanoseconds and are turned into clock counts by rounding up. The refresh interval is a maximum, so it is rounded down.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held, the request, busy and ready outputs are 0. Every row-strobe and column-strobe line is 1, and write-enable is 1.
- R2: No request is raised during the power-up pause of PAUSE = ceil(T_PAUSE_NS/CLK_PERIOD_NS) clocks. The first request is seen PAUSE+1 clock edges after reset is released, even if the grant is held high throughout.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles are run (8 by default). The ready output rises on the edge where the last of them raises its row strobe, and not before.
- R4: In each refresh cycle, all column-strobe lanes are low for at least ceil(T_CSR_NS/CLK_PERIOD_NS) clocks before the row strobe falls. They stay low for ceil(T_CHR_NS/CLK_PERIOD_NS) clocks after it falls, and then go high.
- R5: The row strobe stays low for max(ceil(T_RAS_NS), CAS hold) clocks. Between cycles it stays high long enough that the precharge minimum, the column precharge minimum and the full-cycle minimum (ceil(T_RC_NS)) are all met. With the defaults, each cycle is 2 setup + 8 low + 4 recovery = 14 clocks.
- R6: Write-enable is 1 at all times. All bank lines carry one value and all lanes carry one value.
- R7: The strobes only move after the grant is sampled high while a request is pending. A grant while no request is pending has no effect on any output. Busy is 1 only while the request is 1, and the request stays high until the last owed cycle has ended.
- R8: Once ready, the timer adds one owed refresh every REFI = floor(T_REFI_NS/CLK_PERIOD_NS) clocks. The first request comes REFI+1 edges after ready rises, and later requests follow REFI edges apart when the grant is immediate.
- R9: While the grant is withheld, owed refreshes accumulate up to MAX_PENDING (4 by default) without loss of ready. On grant, exactly that many cycles run back to back.
- R10: A timer period that ends while MAX_PENDING refreshes are already owed clears ready and discards the owed count. The next grant then runs WAKE_CYCLES cycles and restores ready, and the interval timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_gnt_i | input | 1 | Host grants the DRAM strobes to the scheduler |
| refresh_req_o | output | 1 | Scheduler asks for the strobes |
| refresh_busy_o | output | 1 | Scheduler is driving the strobes |
| mem_ready_o | output | 1 | Wake-up done; normal accesses allowed |
| ras_n_o | output | NUM_BANKS | Row strobe per bank, active low |
| cas_n_o | output | NUM_LANES | Column strobe per byte lane, active low |
| we_n_o | output | 1 | Write enable, active low, held high |

## Verification
The bench targets the exact edge on which the first request appears after the pause. A design that counted the pause one clock short would touch the DRAM too early. It also targets the count of wake-up cycles on both entries into the burst, after power-up and after a missed deadline. A design that reused the postponed count, or forgot to clear it, would run too few cycles or keep stale work. The boundary between a full postponement budget and one period too many is checked from both sides: an off-by-one cap would either drop ready on a legal delay or let the deadline slip silently. The column-lead, column-hold, row-width and precharge spacing is measured on the pins for every cycle, including back-to-back cycles inside one grant, where a too-short recovery would first show up.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ASK,
        SEQ_SETUP,
        SEQ_STROBE,
        SEQ_RECOVER
    } seq_state_e;

    // Minimum time in ns -> clocks, rounded up, never below one clock.
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cbr_refresh_timer.sv
module cbr_refresh_timer
    import cbr_refresh_pkg::*;
#(
    parameter int PAUSE_CYC = 12500,
    parameter int REFI_CYC  = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en_i,
    output logic pause_done_o,
    output logic tick_o
);
    localparam int PW = cnt_width(PAUSE_CYC);
    localparam int IW = cnt_width(REFI_CYC);

    typedef struct packed {
        logic [PW-1:0] pause_cnt;
        logic          pause_done;
        logic [IW-1:0] ivl_cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        tick_o = 1'b0;
        if (!q.pause_done) begin
            if (q.pause_cnt == PW'(PAUSE_CYC - 1)) begin
                d.pause_done = 1'b1;
            end else begin
                d.pause_cnt = q.pause_cnt + PW'(1);
            end
        end
        if (run_en_i) begin
            if (q.ivl_cnt == IW'(REFI_CYC - 1)) begin
                tick_o    = 1'b1;
                d.ivl_cnt = '0;
            end else begin
                d.ivl_cnt = q.ivl_cnt + IW'(1);
            end
        end else begin
            d.ivl_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pause_done_o = q.pause_done;

    // Interval ticks only ever follow the end of the power-up pause.
    assert_tick_after_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> q.pause_done);

    // Two ticks are never adjacent: the period spans many clocks.
    assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/cbr_refresh_tracker.sv
module cbr_refresh_tracker
    import cbr_refresh_pkg::*;
#(
    parameter int WAKE_CYCLES = 8,
    parameter int MAX_PENDING = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_done_i,
    input  logic tick_i,
    input  logic cycle_done_i,
    output logic have_work_o,
    output logic ready_o
);
    localparam int PNW = cnt_width(MAX_PENDING);
    localparam int WW  = cnt_width(WAKE_CYCLES);

    typedef struct packed {
        logic [PNW-1:0] pend;
        logic [WW-1:0]  wake_left;
        logic           ready;
    } trk_t;

    trk_t q, d;
    logic miss;

    always_comb begin
        d    = q;
        miss = 1'b0;
        // A finished cycle pays off the wake-up burst first, then owed refreshes.
        if (cycle_done_i) begin
            if (q.wake_left != '0) begin
                d.wake_left = q.wake_left - WW'(1);
            end else if (q.pend != '0) begin
                d.pend = q.pend - PNW'(1);
            end
        end
        if (tick_i) begin
            if (d.pend == PNW'(MAX_PENDING)) begin
                miss        = 1'b1;
                d.pend      = '0;
                d.wake_left = WW'(WAKE_CYCLES);
                d.ready     = 1'b0;
            end else begin
                d.pend = d.pend + PNW'(1);
            end
        end
        if (!q.ready && cycle_done_i && q.wake_left == WW'(1) && !miss) begin
            d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pend      <= '0;
            q.wake_left <= WW'(WAKE_CYCLES);
            q.ready     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign have_work_o = ((q.wake_left != '0) && pause_done_i) || (q.pend != '0);
    assign ready_o     = q.ready;

    assert_pending_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend <= PNW'(MAX_PENDING));

    assert_ready_after_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ready) |-> $past(cycle_done_i));

    assert_miss_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ready) |-> $past(tick_i));

endmodule

// File: rtl/cbr_refresh_sequencer.sv
module cbr_refresh_sequencer
    import cbr_refresh_pkg::*;
#(
    parameter int CSR_CYC = 2,
    parameter int CHR_CYC = 2,
    parameter int ACT_CYC = 8,
    parameter int PRE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic have_work_i,
    input  logic gnt_i,
    output logic req_o,
    output logic busy_o,
    output logic cas_low_o,
    output logic ras_low_o,
    output logic cycle_done_o
);
    localparam int CW = cnt_width(max2(CSR_CYC, max2(ACT_CYC, PRE_CYC)));
    localparam int RW = cnt_width(CSR_CYC + ACT_CYC + PRE_CYC);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          req;
        logic          busy;
        logic          cas_low;
        logic          ras_low;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d            = q;
        cycle_done_o = 1'b0;
        unique case (q.state)
            SEQ_IDLE: begin
                if (have_work_i) d.state = SEQ_ASK;
            end
            SEQ_ASK: begin
                if (gnt_i) begin
                    d.state = SEQ_SETUP;
                    d.cnt   = '0;
                end
            end
            SEQ_SETUP: begin
                if (q.cnt == CW'(CSR_CYC - 1)) begin
                    d.state = SEQ_STROBE;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            SEQ_STROBE: begin
                if (q.cnt == CW'(ACT_CYC - 1)) begin
                    d.state      = SEQ_RECOVER;
                    d.cnt        = '0;
                    cycle_done_o = 1'b1;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            SEQ_RECOVER: begin
                if (q.cnt == CW'(PRE_CYC - 1)) begin
                    d.cnt   = '0;
                    d.state = have_work_i ? SEQ_SETUP : SEQ_IDLE;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
        // Strobes are registered: derive them from the next state.
        d.req     = (d.state != SEQ_IDLE);
        d.busy    = (d.state == SEQ_SETUP) || (d.state == SEQ_STROBE) ||
                    (d.state == SEQ_RECOVER);
        d.ras_low = (d.state == SEQ_STROBE);
        d.cas_low = (d.state == SEQ_SETUP) ||
                    ((d.state == SEQ_STROBE) && (d.cnt < CW'(CHR_CYC)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= SEQ_IDLE;
            q.cnt     <= '0;
            q.req     <= 1'b0;
            q.busy    <= 1'b0;
            q.cas_low <= 1'b0;
            q.ras_low <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_o     = q.req;
    assign busy_o    = q.busy;
    assign cas_low_o = q.cas_low;
    assign ras_low_o = q.ras_low;

    // Run-length counters that exist only for the checks below.
    logic [RW-1:0] lo_run_q, hi_run_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run_q <= '0;
            hi_run_q <= '0;
            seen_q   <= 1'b0;
        end else begin
            lo_run_q <= q.ras_low  ? ((lo_run_q == '1) ? lo_run_q : lo_run_q + RW'(1)) : '0;
            hi_run_q <= !q.ras_low ? ((hi_run_q == '1) ? hi_run_q : hi_run_q + RW'(1)) : '0;
            seen_q   <= seen_q | q.ras_low;
        end
    end

    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ras_low) |-> $past(q.cas_low));

    assert_ras_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ras_low) |-> (lo_run_q >= RW'(ACT_CYC)));

    assert_ras_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.ras_low) && seen_q) |-> (hi_run_q >= RW'(PRE_CYC + CSR_CYC)));

    assert_busy_under_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> q.req);

    assert_wait_for_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_ASK && !gnt_i) |=> !q.busy);

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_refresh_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_REFI_NS     = 15625,
    parameter int T_PAUSE_NS    = 100000,
    parameter int T_CSR_NS      = 10,
    parameter int T_CHR_NS      = 10,
    parameter int T_RAS_NS      = 60,
    parameter int T_RP_NS       = 40,
    parameter int T_RC_NS       = 110,
    parameter int T_CP_NS       = 10,
    parameter int WAKE_CYCLES   = 8,
    parameter int MAX_PENDING   = 4,
    parameter int NUM_BANKS     = 4,
    parameter int NUM_LANES     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 refresh_gnt_i,
    output logic                 refresh_req_o,
    output logic                 refresh_busy_o,
    output logic                 mem_ready_o,
    output logic [NUM_BANKS-1:0] ras_n_o,
    output logic [NUM_LANES-1:0] cas_n_o,
    output logic                 we_n_o
);
    localparam int CSR_CYC   = ns_to_cycles(T_CSR_NS, CLK_PERIOD_NS);
    localparam int CHR_CYC   = ns_to_cycles(T_CHR_NS, CLK_PERIOD_NS);
    localparam int RAS_MIN   = ns_to_cycles(T_RAS_NS, CLK_PERIOD_NS);
    localparam int RP_MIN    = ns_to_cycles(T_RP_NS, CLK_PERIOD_NS);
    localparam int RC_MIN    = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int CP_MIN    = ns_to_cycles(T_CP_NS, CLK_PERIOD_NS);
    localparam int ACT_CYC   = max2(RAS_MIN, CHR_CYC);
    // Recovery plus the next setup is the row-strobe high time.
    localparam int PRE_CYC   = max2(1, max2(RP_MIN - CSR_CYC,
                                   max2(RC_MIN - ACT_CYC - CSR_CYC,
                                        CP_MIN - (ACT_CYC - CHR_CYC))));
    localparam int REFI_RAW  = T_REFI_NS / CLK_PERIOD_NS;
    localparam int REFI_CYC  = (REFI_RAW < 2) ? 2 : REFI_RAW;
    localparam int PAUSE_CYC = ns_to_cycles(T_PAUSE_NS, CLK_PERIOD_NS);

    logic pause_done, tick, cycle_done, have_work, ready;
    logic cas_low, ras_low;

    cbr_refresh_timer #(
        .PAUSE_CYC (PAUSE_CYC),
        .REFI_CYC  (REFI_CYC)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en_i     (ready),
        .pause_done_o (pause_done),
        .tick_o       (tick)
    );

    cbr_refresh_tracker #(
        .WAKE_CYCLES (WAKE_CYCLES),
        .MAX_PENDING (MAX_PENDING)
    ) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .pause_done_i (pause_done),
        .tick_i       (tick),
        .cycle_done_i (cycle_done),
        .have_work_o  (have_work),
        .ready_o      (ready)
    );

    cbr_refresh_sequencer #(
        .CSR_CYC (CSR_CYC),
        .CHR_CYC (CHR_CYC),
        .ACT_CYC (ACT_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .have_work_i  (have_work),
        .gnt_i        (refresh_gnt_i),
        .req_o        (refresh_req_o),
        .busy_o       (refresh_busy_o),
        .cas_low_o    (cas_low),
        .ras_low_o    (ras_low),
        .cycle_done_o (cycle_done)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ras_n_o[b] = ~ras_low;
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign cas_n_o[l] = ~cas_low;
    end

    assign we_n_o      = 1'b1;
    assign mem_ready_o = ready;

    // Strobes only move while the scheduler owns the bus.
    assert_strobes_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_low || cas_low) |-> (refresh_busy_o && refresh_req_o));

endmodule

// File: tb/cbr_refresh_sched_bench.sv
module cbr_refresh_sched_bench;
    localparam int PER   = 8;
    localparam int NB    = 4;
    localparam int NL    = 4;
    localparam int WAKE  = 8;
    localparam int MAXP  = 4;
    // Expected clock counts, worked out from the requirements.
    localparam int CSR   = (10 + PER - 1) / PER;
    localparam int CHR   = (10 + PER - 1) / PER;
    localparam int RASC  = (60 + PER - 1) / PER;
    localparam int RPC   = (40 + PER - 1) / PER;
    localparam int RCC   = (110 + PER - 1) / PER;
    localparam int ACT   = (RASC > CHR) ? RASC : CHR;
    localparam int PRE   = 4;
    localparam int CYC   = CSR + ACT + PRE;
    localparam int REFI  = 15625 / PER;
    localparam int PAUSE = (100000 + PER - 1) / PER;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, busy, ready, we_n;
    logic [NB-1:0] ras_n;
    logic [NL-1:0] cas_n;

    always #(PER / 2) clk = ~clk;

    cbr_refresh_sched #(
        .CLK_PERIOD_NS (PER), .T_REFI_NS (15625), .T_PAUSE_NS (100000),
        .T_CSR_NS (10), .T_CHR_NS (10), .T_RAS_NS (60), .T_RP_NS (40),
        .T_RC_NS (110), .T_CP_NS (10), .WAKE_CYCLES (WAKE),
        .MAX_PENDING (MAXP), .NUM_BANKS (NB), .NUM_LANES (NL)
    ) u_cbr_refresh_sched (
        .clk (clk), .rst_n (rst_n), .refresh_gnt_i (gnt),
        .refresh_req_o (req), .refresh_busy_o (busy), .mem_ready_o (ready),
        .ras_n_o (ras_n), .cas_n_o (cas_n), .we_n_o (we_n)
    );

    int total = 0;
    int fails = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: counts, a phase and a position in the cycle.
    int m_elapsed, m_ivl, m_pend, m_wake, m_phase, m_pos, edges;
    bit m_ready;

    always @(posedge clk) begin : model
        bit work, done, tick;
        int n_pend, n_wake;
        bit n_ready;
        if (!rst_n) begin
            m_elapsed = 0; m_ivl = 0; m_pend = 0; m_wake = WAKE;
            m_phase = 0; m_pos = 0; m_ready = 0; edges = 0;
        end else begin
            edges++;
            work = (m_wake > 0 && m_elapsed >= PAUSE) || m_pend > 0;
            done = (m_phase == 2) && (m_pos == CSR + ACT - 1);
            tick = m_ready && (m_ivl == REFI - 1);
            n_pend = m_pend; n_wake = m_wake; n_ready = m_ready;
            if (done) begin
                if (n_wake > 0) begin
                    n_wake--;
                    if (n_wake == 0) n_ready = 1;
                end else if (n_pend > 0) n_pend--;
            end
            if (tick) begin
                if (n_pend == MAXP) begin
                    n_pend = 0; n_wake = WAKE; n_ready = 0;
                end else n_pend++;
            end
            if (m_ready) m_ivl = tick ? 0 : m_ivl + 1;
            else m_ivl = 0;
            if (m_elapsed < PAUSE) m_elapsed++;
            case (m_phase)
                0: if (work) m_phase = 1;
                1: if (gnt) begin m_phase = 2; m_pos = 0; end
                default: begin
                    if (m_pos == CYC - 1) begin
                        m_pos = 0;
                        m_phase = work ? 2 : 0;
                    end else m_pos++;
                end
            endcase
            m_pend = n_pend; m_wake = n_wake; m_ready = n_ready;
        end
    end

    // Per-clock comparison and pin-level timing monitors.
    int ras_fall_cnt = 0, req_rise_cnt = 0;
    int req_rise_edge = 0, prev_req_rise_edge = 0, ready_rise_edge = 0;
    int cas_low_run = 0, ras_low_run = 0, ras_high_run = 0, last_low_len = 0;
    bit prev_ras = 1, prev_cas = 1, prev_req = 0, prev_ready = 0, seen_ras = 0;

    always @(negedge clk) begin : compare
        bit e_ras, e_cas, ras_lo, cas_lo;
        if (rst_n) begin
            e_ras = (m_phase == 2) && (m_pos >= CSR) && (m_pos < CSR + ACT);
            e_cas = (m_phase == 2) && (m_pos < CSR + CHR);
            check(req === (m_phase != 0), "R7", "request", req, m_phase != 0);
            check(busy === (m_phase == 2), "R7", "busy", busy, m_phase == 2);
            check(ras_n === {NB{~e_ras}}, "R5", "row strobes", ras_n, {NB{~e_ras}});
            check(cas_n === {NL{~e_cas}}, "R4", "column strobes", cas_n, {NL{~e_cas}});
            check(we_n === 1'b1, "R6", "write enable", we_n, 1);
            check(ready === m_ready, "R3", "ready", ready, m_ready);
            check((&ras_n) == (|ras_n) && (&cas_n) == (|cas_n), "R6",
                  "lanes uniform", {ras_n, cas_n}, {NB + NL{ras_n[0]}});
            ras_lo = !ras_n[0];
            cas_lo = !cas_n[0];
            if (prev_ras && ras_lo) begin
                check(cas_low_run >= CSR, "R4", "column lead", cas_low_run, CSR);
                if (seen_ras) begin
                    check(ras_high_run >= RPC, "R5", "precharge", ras_high_run, RPC);
                    check(ras_high_run + last_low_len >= RCC, "R5", "cycle length",
                          ras_high_run + last_low_len, RCC);
                end
                ras_fall_cnt++;
                seen_ras = 1;
            end
            if (!prev_ras && !ras_lo) begin
                check(ras_low_run >= RASC, "R5", "row low width", ras_low_run, RASC);
                last_low_len = ras_low_run;
            end
            if (!prev_cas && !cas_lo && ras_lo)
                check(ras_low_run >= CHR, "R4", "column hold", ras_low_run, CHR);
            if (!prev_req && req) begin
                prev_req_rise_edge = req_rise_edge;
                req_rise_edge = edges;
                req_rise_cnt++;
            end
            if (!prev_ready && ready) ready_rise_edge = edges;
            cas_low_run  = cas_lo ? cas_low_run + 1 : 0;
            ras_low_run  = ras_lo ? ras_low_run + 1 : 0;
            ras_high_run = ras_lo ? 0 : ras_high_run + 1;
            prev_ras = !ras_lo; prev_cas = !cas_lo; prev_req = req; prev_ready = ready;
            prev_ras = ras_n[0]; prev_cas = cas_n[0];
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        check(0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin : stimulus
        int f0, rc;
        gnt = 1'b1;
        repeat (3) step();
        // R1: reset values
        check(req === 1'b0 && busy === 1'b0, "R1", "req/busy in reset", {req, busy}, 0);
        check(ready === 1'b0, "R1", "ready in reset", ready, 0);
        check(ras_n === '1 && cas_n === '1 && we_n === 1'b1, "R1", "strobes in reset",
              {ras_n, cas_n, we_n}, '1);
        rst_n = 1'b1;
        repeat (100) step();
        // R7: a grant with nothing requested leaves the strobes alone (R2 pause too)
        check(req === 1'b0 && ras_n === '1 && cas_n === '1, "R7", "grant while idle",
              {req, ras_n, cas_n}, {1'b0, {NB + NL{1'b1}}});
        while (req !== 1'b1) step();
        check(edges == PAUSE + 1, "R2", "first request edge", edges, PAUSE + 1);
        while (ready !== 1'b1) step();
        check(ras_fall_cnt == WAKE, "R3", "wake-up cycles", ras_fall_cnt, WAKE);
        // R8: interval timing with immediate grant
        rc = req_rise_cnt;
        while (req_rise_cnt == rc) step();
        check(req_rise_edge - ready_rise_edge == REFI + 1, "R8", "first interval",
              req_rise_edge - ready_rise_edge, REFI + 1);
        rc = req_rise_cnt;
        while (req_rise_cnt == rc) step();
        check(req_rise_edge - prev_req_rise_edge == REFI, "R8", "steady interval",
              req_rise_edge - prev_req_rise_edge, REFI);
        // R9: postpone up to the budget
        while (busy === 1'b1 || req === 1'b1) step();
        gnt = 1'b0;
        rc = req_rise_cnt;
        while (req_rise_cnt == rc) step();
        repeat (3 * REFI + 20) step();
        check(ready === 1'b1, "R9", "ready kept within budget", ready, 1);
        check(busy === 1'b0, "R7", "no strobes without grant", busy, 0);
        f0 = ras_fall_cnt;
        gnt = 1'b1;
        step();
        while (req === 1'b1) step();
        check(ras_fall_cnt - f0 == MAXP, "R9", "postponed cycles", ras_fall_cnt - f0, MAXP);
        // R10: one period too many
        gnt = 1'b0;
        rc = req_rise_cnt;
        while (req_rise_cnt == rc) step();
        repeat (4 * REFI + 20) step();
        check(ready === 1'b0, "R10", "ready dropped on miss", ready, 0);
        f0 = ras_fall_cnt;
        gnt = 1'b1;
        step();
        while (req === 1'b1) step();
        check(ras_fall_cnt - f0 == WAKE, "R10", "wake-up after miss", ras_fall_cnt - f0, WAKE);
        check(ready === 1'b1, "R10", "ready restored", ready, 1);
        rc = req_rise_cnt;
        while (req_rise_cnt == rc) step();
        check(req_rise_edge - ready_rise_edge == REFI + 1, "R10", "timer restarted",
              req_rise_edge - ready_rise_edge, REFI + 1);
        repeat (40) step();
        finish_run();
    end

endmodule